// File: doc/BRIEF.md
# Dual-PWM FSK Packet Transmitter

This block sends one power-line packet as a frequency-shift-keyed carrier. A one-cycle `start` strobe captures a payload of `NUM_BYTES` bytes. The block then serializes a fixed packet: a 16-bit alternating preamble (0xAAAA), a 16-bit word sync (0x54C7), the payload bytes, and a 24-bit closing field. Each bit selects the carrier frequency. A 1 gives the mark tone, which has the longer period. A 0 gives the space tone. Each bit is held for a fixed number of carrier periods.

A single up/down counter produces the carrier. Two compare outputs are taken from that counter, one near one-third duty and one near two-thirds duty. An external analog stage sums and filters them into a sine wave whose third harmonic is largely cancelled. A new period value is taken only when the counter is at zero, so the waveform never jumps mid-cycle.

`busy` stays high for the whole packet and can drive a transmit indicator. `done` pulses once when the packet ends and the line is handed back to the receiver. An optional differential precode can be enabled by parameter. It replaces each payload bit with its XOR against the previously sent bit.

Top module: `fsk_packet_tx`

## Requirements
- R1: After reset, and whenever no packet is in progress, `busy`, `done`, `pwm_a` and `pwm_b` are all low.
- R2: A `start` sampled high while idle loads `payload` and raises `busy` on the next cycle. `busy` then stays high for exactly the sum, over all packet bits, of `PERIODS_PER_BIT` × 2 × top ticks, where top is `TOP_MARK` for a 1 bit and `TOP_SPACE` for a 0 bit.
- R3: The sent bit order is 0xAAAA MSB first, then 0x54C7 MSB first, then payload byte 0 (`payload[7:0]`), byte 1 and onward, each MSB first, then the 24-bit `TRAILER` MSB first (zero by default).
- R4: Each bit lasts exactly `PERIODS_PER_BIT` carrier periods. One period of top T is 2T cycles, during which the counter value runs 0,1,…,T,T−1,…,1.
- R5: Within a period of top T at counter value v, `pwm_a` is high when v > T − ⌊T/3⌋ and `pwm_b` is high when v > T − ⌊2T/3⌋. The high times are therefore 2⌊T/3⌋−1 and 2⌊2T/3⌋−1 cycles, and `pwm_a` high implies `pwm_b` high.
- R6: A change of carrier period takes effect only in a cycle where the counter is zero. The counter never exceeds the active top, so consecutive periods join without a discontinuity.
- R7: `done` is high for exactly one cycle: the first cycle in which `busy` is low after a packet.
- R8: A `start`, or a change of `payload`, while `busy` is high has no effect on the packet being sent.
- R9: With `DIFF_EN`=1, each payload bit is sent as its XOR with the bit sent just before it. The first payload bit is combined with the last word-sync bit (1). The preamble, sync and trailer are sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to send a packet |
| payload | input | NUM_BYTES*8 | Payload bytes, byte 0 in bits [7:0] |
| pwm_a | output | 1 | Compare output near one-third duty |
| pwm_b | output | 1 | Compare output near two-thirds duty |
| busy | output | 1 | High while a packet is on the line |
| done | output | 1 | One-cycle pulse at the end of a packet |

## Verification
The carrier is due in the first cycle after the edge that samples `start`. In that cycle the counter is at zero and both outputs are low. From then on, every cycle has a known counter value derived from the bit list and the two top values. The bench rebuilds that sequence arithmetically for every bit and compares both compare outputs and `busy` on each falling edge. `done` is checked in the single cycle right after the last counter tick and is checked to be low again one cycle later. Late `start` pulses and payload changes are injected mid-packet, and the comparison continues against the originally loaded payload.

// File: rtl/fsk_tx_pkg.sv
// Package: packet field widths, fixed patterns and shared types for the
// FSK packet transmitter. Assumes MSB-first transmission of every field.
package fsk_tx_pkg;
    localparam int unsigned PRE_W   = 16;
    localparam int unsigned SYNC_W  = 16;
    localparam int unsigned TRAIL_W = 24;
    localparam logic [PRE_W-1:0]  PRE_PATTERN  = 16'hAAAA;
    localparam logic [SYNC_W-1:0] SYNC_PATTERN = 16'h54C7;

    typedef enum logic {SEQ_IDLE, SEQ_SEND} seq_state_e;

    // Compare level for a fraction num/3 of top: output high above it.
    function automatic int unsigned cmp_level(input int unsigned top, input int unsigned num);
        return top - (top * num) / 3;
    endfunction
endpackage

// File: rtl/fsk_carrier_gen.sv
// Carrier generator: one up/down counter shared by two compare outputs.
// The top value and both compare levels are shadowed and latched only when
// the counter is at zero, so a period change never cuts a cycle short.
// Assumes top_in >= 3 and that run is low for at least one cycle after reset.
module fsk_carrier_gen #(
    parameter int unsigned CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] top_in,
    input  logic [CW-1:0] lvl_a_in,
    input  logic [CW-1:0] lvl_b_in,
    output logic          pwm_a,
    output logic          pwm_b,
    output logic          cyc_end
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] top_q;
    logic [CW-1:0] lvl_a_q;
    logic [CW-1:0] lvl_b_q;
    logic          down_q;

    // Counter sweep and shadow latch of period and compare levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            down_q  <= 1'b0;
            top_q   <= '0;
            lvl_a_q <= '0;
            lvl_b_q <= '0;
        end else if (!run) begin
            cnt_q   <= '0;
            down_q  <= 1'b0;
            top_q   <= top_in;
            lvl_a_q <= lvl_a_in;
            lvl_b_q <= lvl_b_in;
        end else begin
            if (cnt_q == '0) begin
                top_q   <= top_in;
                lvl_a_q <= lvl_a_in;
                lvl_b_q <= lvl_b_in;
            end
            if (!down_q) begin
                cnt_q <= cnt_q + CW'(1);
                if (cnt_q + CW'(1) == top_q) begin
                    down_q <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    down_q <= 1'b0;
                end
            end
        end
    end

    // Compare outputs and end-of-period marker.
    always_comb begin
        pwm_a   = run && (cnt_q > lvl_a_q);
        pwm_b   = run && (cnt_q > lvl_b_q);
        cyc_end = run && down_q && (cnt_q == CW'(1));
    end

    // R6
    top_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run && $past(cnt_q) != '0) |-> $stable(top_q));
    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= top_q));
    // R4
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && run) |=> (cnt_q == '0));
    // R5
    nest_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_a |-> pwm_b);
endmodule

// File: rtl/fsk_bit_seq.sv
// Bit sequencer: captures the payload on start, holds the whole packet in a
// shift register and presents one sent bit at a time. It advances after a
// fixed number of carrier periods and applies the optional differential
// precode to payload bits. Assumes cyc_end pulses once per carrier period.
module fsk_bit_seq
    import fsk_tx_pkg::*;
#(
    parameter int unsigned         NUM_BYTES       = 38,
    parameter int unsigned         PERIODS_PER_BIT = 51,
    parameter bit                  DIFF_EN         = 1'b0,
    parameter logic [TRAIL_W-1:0]  TRAILER         = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NUM_BYTES*8-1:0] payload,
    input  logic                   cyc_end,
    output logic                   busy,
    output logic                   done,
    output logic                   cur_bit
);
    localparam int unsigned DATA_W  = NUM_BYTES * 8;
    localparam int unsigned TOTAL   = PRE_W + SYNC_W + DATA_W + TRAIL_W;
    localparam int unsigned DATA_LO = PRE_W + SYNC_W;
    localparam int unsigned DATA_HI = DATA_LO + DATA_W;
    localparam int unsigned POS_W   = $clog2(TOTAL);
    localparam int unsigned PER_W   = (PERIODS_PER_BIT > 1) ? $clog2(PERIODS_PER_BIT) : 1;

    seq_state_e        state_q;
    logic [TOTAL-1:0]  sr_q;
    logic [TOTAL-1:0]  sr_init;
    logic [DATA_W-1:0] data_msb;
    logic [POS_W-1:0]  pos_q;
    logic [PER_W-1:0]  per_q;
    logic              bit_q;
    logic              done_q;
    logic              next_sent;
    logic              last_per;

    // Byte 0 goes first on the line: reorder the bytes so it sits at the top.
    for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_reorder
        assign data_msb[(NUM_BYTES-1-gi)*8 +: 8] = payload[gi*8 +: 8];
    end
    assign sr_init = {PRE_PATTERN, SYNC_PATTERN, data_msb, TRAILER};

    // Next sent bit, with the differential precode inside the payload field.
    always_comb begin
        logic [POS_W-1:0] npos;
        npos      = pos_q + POS_W'(1);
        next_sent = sr_q[TOTAL-2];
        if (DIFF_EN && (npos >= POS_W'(DATA_LO)) && (npos < POS_W'(DATA_HI))) begin
            next_sent = sr_q[TOTAL-2] ^ bit_q;
        end
        last_per = (per_q == PER_W'(PERIODS_PER_BIT - 1));
    end

    // Packet state, bit position and period counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            sr_q    <= '0;
            pos_q   <= '0;
            per_q   <= '0;
            bit_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == SEQ_IDLE) begin
                if (start) begin
                    state_q <= SEQ_SEND;
                    sr_q    <= sr_init;
                    pos_q   <= '0;
                    per_q   <= '0;
                    bit_q   <= sr_init[TOTAL-1];
                end
            end else if (cyc_end) begin
                if (!last_per) begin
                    per_q <= per_q + PER_W'(1);
                end else begin
                    per_q <= '0;
                    if (pos_q == POS_W'(TOTAL - 1)) begin
                        state_q <= SEQ_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        pos_q <= pos_q + POS_W'(1);
                        sr_q  <= sr_q << 1;
                        bit_q <= next_sent;
                    end
                end
            end
        end
    end

    assign busy    = (state_q == SEQ_SEND);
    assign done    = done_q;
    assign cur_bit = bit_q;

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && pos_q == '0));
    // R8
    start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !cyc_end) |=> ($stable(sr_q) && $stable(pos_q)));
    // R4
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cyc_end) |=> $stable(bit_q));
    // R7
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/fsk_packet_tx.sv
// Top: FSK packet transmitter. The sequencer picks the sent bit and this
// level maps it to a mark (1) or space (0) top and compare levels, all
// constants, which the carrier generator shadows at counter zero.
// Assumes both top values are at least 3.
module fsk_packet_tx
    import fsk_tx_pkg::*;
#(
    parameter int unsigned        NUM_BYTES       = 38,
    parameter int unsigned        TOP_SPACE       = 675,
    parameter int unsigned        TOP_MARK        = 789,
    parameter int unsigned        PERIODS_PER_BIT = 51,
    parameter bit                 DIFF_EN         = 1'b0,
    parameter logic [TRAIL_W-1:0] TRAILER         = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NUM_BYTES*8-1:0] payload,
    output logic                   pwm_a,
    output logic                   pwm_b,
    output logic                   busy,
    output logic                   done
);
    localparam int unsigned TOP_MAX = (TOP_MARK > TOP_SPACE) ? TOP_MARK : TOP_SPACE;
    localparam int unsigned CW      = $clog2(TOP_MAX + 1);
    localparam logic [CW-1:0] LA_S  = CW'(cmp_level(TOP_SPACE, 1));
    localparam logic [CW-1:0] LB_S  = CW'(cmp_level(TOP_SPACE, 2));
    localparam logic [CW-1:0] LA_M  = CW'(cmp_level(TOP_MARK, 1));
    localparam logic [CW-1:0] LB_M  = CW'(cmp_level(TOP_MARK, 2));

    logic          cur_bit;
    logic          cyc_end;
    logic [CW-1:0] top_sel;
    logic [CW-1:0] lvl_a_sel;
    logic [CW-1:0] lvl_b_sel;

    // Frequency select for the bit being sent.
    always_comb begin
        top_sel   = cur_bit ? CW'(TOP_MARK) : CW'(TOP_SPACE);
        lvl_a_sel = cur_bit ? LA_M : LA_S;
        lvl_b_sel = cur_bit ? LB_M : LB_S;
    end

    fsk_bit_seq #(
        .NUM_BYTES       (NUM_BYTES),
        .PERIODS_PER_BIT (PERIODS_PER_BIT),
        .DIFF_EN         (DIFF_EN),
        .TRAILER         (TRAILER)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .payload (payload),
        .cyc_end (cyc_end),
        .busy    (busy),
        .done    (done),
        .cur_bit (cur_bit)
    );

    fsk_carrier_gen #(
        .CW (CW)
    ) u_car (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .top_in   (top_sel),
        .lvl_a_in (lvl_a_sel),
        .lvl_b_in (lvl_b_sel),
        .pwm_a    (pwm_a),
        .pwm_b    (pwm_b),
        .cyc_end  (cyc_end)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pwm_a && !pwm_b));
endmodule

// File: tb/sim_fsk_packet_tx.sv
module sim_fsk_packet_tx;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 2;
    localparam int TS    = 6;
    localparam int TM    = 9;
    localparam int CYC   = 2;
    localparam int NBITS = 32 + NB * 8 + 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] start_v = 2'b00;
    logic [NB*8-1:0] payload = '0;
    logic a0, b0, busy0, done0, a1, b1, busy1, done1;
    logic sel = 1'b0;
    logic o_a, o_b, o_busy, o_done;
    logic exp_bits [NBITS];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_packet_tx #(.NUM_BYTES(NB), .TOP_SPACE(TS), .TOP_MARK(TM),
                    .PERIODS_PER_BIT(CYC), .DIFF_EN(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start_v[0]), .payload(payload),
        .pwm_a(a0), .pwm_b(b0), .busy(busy0), .done(done0));

    fsk_packet_tx #(.NUM_BYTES(NB), .TOP_SPACE(TS), .TOP_MARK(TM),
                    .PERIODS_PER_BIT(CYC), .DIFF_EN(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start_v[1]), .payload(payload),
        .pwm_a(a1), .pwm_b(b1), .busy(busy1), .done(done1));

    assign o_a    = sel ? a1 : a0;
    assign o_b    = sel ? b1 : b0;
    assign o_busy = sel ? busy1 : busy0;
    assign o_done = sel ? done1 : done0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R3 R9: expected sent bit list
    task automatic build(input logic [NB*8-1:0] pl, input bit diff);
        logic [15:0] pre;
        logic [15:0] syn;
        logic prev;
        pre = 16'hAAAA;
        syn = 16'h54C7;
        prev = 1'b0;
        for (int i = 0; i < NBITS; i++) begin
            logic raw;
            int j;
            j = i - 32;
            if (i < 16) raw = pre[15-i];
            else if (i < 32) raw = syn[31-i];
            else if (i < 32 + NB*8) begin
                raw = pl[(j/8)*8 + 7 - (j%8)];
                if (diff) raw = raw ^ prev;
            end else raw = 1'b0;
            exp_bits[i] = raw;
            prev = raw;
        end
    endtask

    // Runs one packet on the selected instance, comparing every cycle.
    task automatic run_pkt(input int which, input logic [NB*8-1:0] pl, input bit poke);
        int tick;
        int total_bad;
        string req;
        tick = 0;
        total_bad = 0;
        req = (which == 1) ? "R9" : (poke ? "R8" : "R3");
        sel = (which == 1);
        payload = pl;
        build(pl, which == 1);
        start_v[which] = 1'b1;
        @(negedge clk);
        start_v = 2'b00;
        chk(o_busy == 1'b1, "R2", "busy after start", int'(o_busy), 1);
        for (int bi = 0; bi < NBITS; bi++) begin
            int t;
            int bad_a;
            int bad_b;
            int bad_busy;
            t = exp_bits[bi] ? TM : TS;
            bad_a = 0;
            bad_b = 0;
            bad_busy = 0;
            for (int p = 0; p < CYC; p++) begin
                for (int k = 0; k < 2*t; k++) begin
                    int v;
                    logic ea;
                    logic eb;
                    v = (k <= t) ? k : 2*t - k;
                    ea = (v > t - t/3);
                    eb = (v > t - (2*t)/3);
                    if (o_a !== ea) bad_a++;
                    if (o_b !== eb) bad_b++;
                    if (o_busy !== 1'b1) bad_busy++;
                    if (poke && (tick == 40 || tick == 300)) begin
                        start_v[which] = 1'b1;
                        payload = ~pl;
                    end else begin
                        start_v = 2'b00;
                    end
                    tick++;
                    @(negedge clk);
                end
            end
            // R3 R4 R6: carrier period per bit, phase-continuous joins
            chk(bad_b == 0, "R3 R4 R6", $sformatf("pwm_b mismatches bit %0d", bi), bad_b, 0);
            // R5: one-third compare output
            chk(bad_a == 0, "R5", $sformatf("pwm_a mismatches bit %0d", bi), bad_a, 0);
            total_bad += bad_a + bad_b + bad_busy;
            if (bad_busy != 0) chk(1'b0, "R2", "busy dropped inside packet", bad_busy, 0);
        end
        chk(total_bad == 0, req, "packet mismatch cycles", total_bad, 0);
        // R2 R7: busy ends exactly after the computed length, done that cycle
        chk(o_busy == 1'b0, "R2", "busy after last period", int'(o_busy), 0);
        chk(o_done == 1'b1, "R7", "done at end", int'(o_done), 1);
        @(negedge clk);
        chk(o_done == 1'b0, "R7", "done second cycle", int'(o_done), 0);
        payload = pl;
    endtask

    task automatic idle_check(input int n);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (a0 | b0 | busy0 | done0 | a1 | b1 | busy1 | done1) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R1", "idle outputs active", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({a0, b0, busy0, done0} == 4'b0, "R1", "reset outputs u0", int'({a0, b0, busy0, done0}), 0);
        chk({a1, b1, busy1, done1} == 4'b0, "R1", "reset outputs u1", int'({a1, b1, busy1, done1}), 0);
        rst_n = 1'b1;
        idle_check(5);
        run_pkt(0, 16'h0000, 1'b0);
        idle_check(3);
        run_pkt(0, 16'hFFFF, 1'b0);
        idle_check(3);
        run_pkt(0, 16'h3CA5, 1'b0);
        run_pkt(0, 16'h8001, 1'b1);
        idle_check(3);
        run_pkt(1, 16'h0000, 1'b0);
        idle_check(3);
        run_pkt(1, 16'hFFFF, 1'b0);
        run_pkt(1, 16'h3CA5, 1'b1);
        idle_check(4);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 150000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule